// File: doc/BRIEF.md
# EEPROM Status and Write-Protection Controller

This block is the control core of a byte-wide serial EEPROM with an 11-bit address. A command sequencer decodes the serial traffic and hands the block single-cycle events: enable and disable of writes, loads of the high and low address bytes, the acknowledge edge after each data byte (read or write), and requests to start a write cycle. The block holds the write-enable latch, the two block-protect bits and the address pointer. It decides whether each requested write may go ahead and runs the self-timed write cycle. It exposes a status byte, the current address and three permission flags. The storage array sits outside and follows `cur_addr` and the permission flags.

The write-cycle sequencer has four named states. `ST_IDLE` waits for a start. `ST_ARR_BUSY` is an array byte or page write. `ST_SR_BUSY` is a protection-bit update. `ST_FILL_BUSY` is a whole-array fill. An accepted array, status or fill start moves `ST_IDLE` to the matching busy state. Timer expiry moves every busy state back to `ST_IDLE`. A soft reset or power-on reset forces `ST_IDLE`. When starts coincide, array wins over status, and status wins over fill.

Top module: `eeprom_stat_ctrl`

## Requirements
- R1: `status_byte` is `{4'b0000, prot[1], prot[0], wel, wip}` (bit 0 busy flag, bit 1 enable latch, bits 3:2 protect code). After power-on reset it reads 0x00 and `cur_addr` reads 0.
- R2: `wren_evt` sets the enable latch and `wrdi_evt` clears it. Any accepted write start clears it, and it stays clear even when `wren_evt` arrives in the same cycle as that start.
- R3: `arr_wr_ok` is 1 only when the latch is set, no cycle is running and `cur_addr` is outside the protected region. Code 00 protects nothing. Code 01 protects addresses with both top bits set (0x600-0x7FF). Code 10 protects addresses with the top bit set (0x400-0x7FF). Code 11 protects all addresses.
- R4: A status write (`sr_wr_start`) is accepted only with the latch set and no cycle running, whatever the protect code. The new protect code shows in `status_byte` from the cycle after acceptance, while the cycle is still busy. A rejected status write leaves the code unchanged.
- R5: A fill start is accepted only with the latch set, no cycle running and protect code 00. A rejected fill leaves the busy flag at 0 and the latch unchanged.
- R6: `addr_hi_ld` loads `addr_byte[2:0]` into address bits 10:8, and `addr_lo_ld` loads `addr_byte` into bits 7:0.
- R7: `rd_ack` adds one to the full 11-bit pointer, so 0x7FF rolls over to 0x000.
- R8: `wr_ack` adds one to the low four pointer bits only, so 0x12F becomes 0x120.
- R9: The busy flag is 1 for exactly `WR_CYCLES` clocks after an accepted array or status start, and for exactly `FILL_CYCLES` clocks after an accepted fill. A start during a busy cycle is ignored and does not stretch the cycle.
- R10: `soft_rst` clears the latch, the busy flag and the pointer and keeps the protect code. Only power-on reset clears the protect code.
- R11: When an address load and an acknowledge fall in the same cycle, the load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous soft reset (standby pulse) |
| wren_evt | input | 1 | Enable-writes command executed |
| wrdi_evt | input | 1 | Disable-writes command executed |
| addr_hi_ld | input | 1 | Acknowledge edge after high address byte |
| addr_lo_ld | input | 1 | Acknowledge edge after low address byte |
| addr_byte | input | 8 | Received address byte |
| rd_ack | input | 1 | Acknowledge edge after a read data byte |
| wr_ack | input | 1 | Acknowledge edge after a write data byte |
| arr_wr_start | input | 1 | Request to start an array byte/page write cycle |
| sr_wr_start | input | 1 | Request to start a status write cycle |
| new_prot | input | 2 | Protect code carried by the status write |
| fill_start | input | 1 | Request to start a whole-array fill cycle |
| status_byte | output | 8 | Status byte |
| cur_addr | output | 11 | Current address pointer |
| arr_wr_ok | output | 1 | Array write at `cur_addr` is permitted now |
| sr_wr_ok | output | 1 | Status write is permitted now |
| fill_ok | output | 1 | Fill of the whole array is permitted now |

## Verification
The collision of interest is an enable-writes event in the same cycle as an accepted write start. The latch could end up set or clear, and the requirement says the clear from the start wins. The bench raises `wren_evt` and `arr_wr_start` together on a single edge and expects status 0x01 on the next sample. A second collision drives an address load and `rd_ack` together and expects the loaded address, not the incremented one. The busy-window tests also pulse an enable and a fill start mid-cycle. They expect the latch to survive and the busy flag to drop at the cycle count set by the original start.

// File: rtl/eeprom_stat_pkg.sv
package eeprom_stat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ARR_BUSY  = 2'd1,
        ST_SR_BUSY   = 2'd2,
        ST_FILL_BUSY = 2'd3
    } wc_state_t;

    localparam logic [1:0] PROT_NONE    = 2'b00;
    localparam logic [1:0] PROT_QUARTER = 2'b01;
    localparam logic [1:0] PROT_HALF    = 2'b10;
    localparam logic [1:0] PROT_ALL     = 2'b11;

endpackage

// File: rtl/eeprom_prot_dec.sv
module eeprom_prot_dec #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        prot,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    import eeprom_stat_pkg::*;

    logic [1:0] top2;
    assign top2 = addr[ADDR_W-1 -: 2];

    always_comb begin
        unique case (prot)
            PROT_NONE:    locked = 1'b0;
            PROT_QUARTER: locked = (top2 == 2'b11);
            PROT_HALF:    locked = top2[1];
            PROT_ALL:     locked = 1'b1;
            default:      locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              hi_ld,
    input  logic              lo_ld,
    input  logic [7:0]        byte_in,
    input  logic              rd_inc,
    input  logic              wr_inc,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - 8;

    logic [ADDR_W-1:0] ptr_q;
    logic [PAGE_W-1:0] page_off;

    assign page_off = ptr_q[PAGE_W-1:0] + 1'b1;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ptr_q <= '0;
        end else if (soft_rst) begin
            ptr_q <= '0;
        end else if (hi_ld || lo_ld) begin
            if (hi_ld) ptr_q[ADDR_W-1:8] <= byte_in[HI_W-1:0];
            if (lo_ld) ptr_q[7:0]        <= byte_in;
        end else if (rd_inc) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (wr_inc) begin
            ptr_q[PAGE_W-1:0] <= page_off;
        end
    end

    assign addr = ptr_q;
endmodule

// File: rtl/eeprom_wc_timer.sv
module eeprom_wc_timer #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              cnt_q <= '0;
        else if (soft_rst)       cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/eeprom_stat_ctrl.sv
module eeprom_stat_ctrl #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int WR_CYCLES   = 250000,
    parameter int FILL_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              soft_rst,
    input  logic              wren_evt,
    input  logic              wrdi_evt,
    input  logic              addr_hi_ld,
    input  logic              addr_lo_ld,
    input  logic [7:0]        addr_byte,
    input  logic              rd_ack,
    input  logic              wr_ack,
    input  logic              arr_wr_start,
    input  logic              sr_wr_start,
    input  logic [1:0]        new_prot,
    input  logic              fill_start,
    output logic [7:0]        status_byte,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              arr_wr_ok,
    output logic              sr_wr_ok,
    output logic              fill_ok
);
    import eeprom_stat_pkg::*;

    localparam int MAX_CYC = (FILL_CYCLES > WR_CYCLES) ? FILL_CYCLES : WR_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WR_RELOAD   = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] FILL_RELOAD = CNT_W'(FILL_CYCLES - 1);

    wc_state_t        state_q, state_d;
    logic             wel_q;
    logic [1:0]       prot_q;
    logic             wip;
    logic             locked;
    logic             arr_go, sr_go, fill_go, any_go;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;

    eeprom_prot_dec #(.ADDR_W(ADDR_W)) u_prot (
        .prot   (prot_q),
        .addr   (cur_addr),
        .locked (locked)
    );

    eeprom_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .hi_ld    (addr_hi_ld),
        .lo_ld    (addr_lo_ld),
        .byte_in  (addr_byte),
        .rd_inc   (rd_ack),
        .wr_inc   (wr_ack),
        .addr     (cur_addr)
    );

    eeprom_wc_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign wip       = (state_q != ST_IDLE);
    assign sr_wr_ok  = wel_q && !wip;
    assign arr_wr_ok = sr_wr_ok && !locked;
    assign fill_ok   = sr_wr_ok && (prot_q == PROT_NONE);

    assign arr_go  = arr_wr_start && arr_wr_ok && !soft_rst;
    assign sr_go   = sr_wr_start && sr_wr_ok && !soft_rst && !arr_go;
    assign fill_go = fill_start && fill_ok && !soft_rst && !arr_go && !sr_go;
    assign any_go  = arr_go || sr_go || fill_go;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        state_q <= ST_IDLE;
        else if (soft_rst) state_q <= ST_IDLE;
        else               state_q <= state_d;
    end

    // next state and timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = WR_RELOAD;
        unique case (state_q)
            ST_IDLE: begin
                if (arr_go) begin
                    state_d  = ST_ARR_BUSY;
                    tmr_load = 1'b1;
                end else if (sr_go) begin
                    state_d  = ST_SR_BUSY;
                    tmr_load = 1'b1;
                end else if (fill_go) begin
                    state_d  = ST_FILL_BUSY;
                    tmr_load = 1'b1;
                    tmr_val  = FILL_RELOAD;
                end
            end
            ST_ARR_BUSY, ST_SR_BUSY, ST_FILL_BUSY: begin
                if (tmr_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        wel_q <= 1'b0;
        else if (soft_rst) wel_q <= 1'b0;
        else if (any_go)   wel_q <= 1'b0;
        else if (wrdi_evt) wel_q <= 1'b0;
        else if (wren_evt) wel_q <= 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)      prot_q <= PROT_NONE;
        else if (sr_go)  prot_q <= new_prot;
    end

    assign status_byte = {4'b0000, prot_q, wel_q, wip};
endmodule

// File: rtl/eeprom_stat_ctrl_chk.sv
module eeprom_stat_ctrl_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              por_n,
    input logic              soft_rst,
    input logic              wren_evt,
    input logic              wrdi_evt,
    input logic              addr_hi_ld,
    input logic              addr_lo_ld,
    input logic              rd_ack,
    input logic              wr_ack,
    input logic              arr_wr_start,
    input logic              sr_wr_start,
    input logic              fill_start,
    input logic [7:0]        status_byte,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              arr_wr_ok,
    input logic              sr_wr_ok,
    input logic              fill_ok
);
    logic no_ld;
    assign no_ld = !addr_hi_ld && !addr_lo_ld && !soft_rst;

    AST_WEL_SET: assert property (@(posedge clk) disable iff (!por_n)
        wren_evt && !wrdi_evt && !soft_rst && !arr_wr_start && !sr_wr_start && !fill_start
        |=> status_byte[1]); // R2
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!por_n)
        status_byte[0] |-> !arr_wr_ok && !sr_wr_ok && !fill_ok); // R9
    AST_FILL_GUARD: assert property (@(posedge clk) disable iff (!por_n)
        fill_ok |-> status_byte[3:2] == 2'b00); // R5
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!por_n)
        arr_wr_start && arr_wr_ok && !soft_rst |=> status_byte[0] && !status_byte[1]); // R9
    AST_RD_WRAP: assert property (@(posedge clk) disable iff (!por_n)
        rd_ack && no_ld |=> cur_addr == $past(cur_addr) + 1'b1); // R7
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        wr_ack && !rd_ack && no_ld |=> cur_addr[ADDR_W-1:4] == $past(cur_addr[ADDR_W-1:4])); // R8
    AST_PROT_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> $stable(status_byte[3:2])); // R10
    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        status_byte[7:4] == 4'b0000); // R1
endmodule

bind eeprom_stat_ctrl eeprom_stat_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/eeprom_stat_ctrl_tb.sv
module eeprom_stat_ctrl_tb;
    localparam int WR_CYC   = 20;
    localparam int FILL_CYC = 40;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wren_evt = 1'b0, wrdi_evt = 1'b0;
    logic        addr_hi_ld = 1'b0, addr_lo_ld = 1'b0;
    logic [7:0]  addr_byte = '0;
    logic        rd_ack = 1'b0, wr_ack = 1'b0;
    logic        arr_wr_start = 1'b0, sr_wr_start = 1'b0, fill_start = 1'b0;
    logic [1:0]  new_prot = '0;
    logic [7:0]  status_byte;
    logic [10:0] cur_addr;
    logic        arr_wr_ok, sr_wr_ok, fill_ok;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    eeprom_stat_ctrl #(.WR_CYCLES(WR_CYC), .FILL_CYCLES(FILL_CYC)) u_dut (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst),
        .wren_evt(wren_evt), .wrdi_evt(wrdi_evt),
        .addr_hi_ld(addr_hi_ld), .addr_lo_ld(addr_lo_ld), .addr_byte(addr_byte),
        .rd_ack(rd_ack), .wr_ack(wr_ack),
        .arr_wr_start(arr_wr_start), .sr_wr_start(sr_wr_start),
        .new_prot(new_prot), .fill_start(fill_start),
        .status_byte(status_byte), .cur_addr(cur_addr),
        .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok), .fill_ok(fill_ok)
    );

    // {protect code, address, expected arr_wr_ok with latch set}
    localparam logic [13:0] VEC [10] = '{
        {2'd0, 11'h7FF, 1'b1}, {2'd0, 11'h000, 1'b1},
        {2'd1, 11'h5FF, 1'b1}, {2'd1, 11'h600, 1'b0}, {2'd1, 11'h7FF, 1'b0},
        {2'd2, 11'h3FF, 1'b1}, {2'd2, 11'h400, 1'b0},
        {2'd3, 11'h000, 1'b0}, {2'd3, 11'h3FF, 1'b0}, {2'd0, 11'h600, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_wren();
        wren_evt = 1'b1; tick(); wren_evt = 1'b0;
    endtask

    task automatic do_wrdi();
        wrdi_evt = 1'b1; tick(); wrdi_evt = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && status_byte[0]; i++) tick();
    endtask

    task automatic set_prot(input logic [1:0] p);
        do_wren();
        new_prot = p; sr_wr_start = 1'b1; tick(); sr_wr_start = 1'b0;
        wait_idle();
    endtask

    task automatic load_addr(input logic [10:0] a);
        addr_byte = {5'b11111, a[10:8]}; addr_hi_ld = 1'b1; tick(); addr_hi_ld = 1'b0;
        addr_byte = a[7:0]; addr_lo_ld = 1'b1; tick(); addr_lo_ld = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        while (status_byte[0] && n < 1000) begin n++; tick(); end
    endtask

    initial begin
        int n;
        tick(); tick();
        por_n = 1'b1;
        tick();
        check("R1 reset status", status_byte, 8'h00);
        check("R1 reset addr", cur_addr, 0);

        // R2 latch set / clear
        do_wren();
        check("R2 wren", status_byte, 8'h02);
        do_wrdi();
        check("R2 wrdi", status_byte, 8'h00);

        // R3 vector walk over protection codes
        for (int v = 0; v < 10; v++) begin
            set_prot(VEC[v][13:12]);
            check("R4 prot visible", status_byte[3:2], VEC[v][13:12]);
            load_addr(VEC[v][11:1]);
            check("R3 no latch", arr_wr_ok, 0);
            do_wren();
            check("R3 prot decode", arr_wr_ok, VEC[v][0]);
            do_wrdi();
        end

        // R9 array write duration and R2 latch cleared
        set_prot(2'd0);
        load_addr(11'h010);
        do_wren();
        arr_wr_start = 1'b1; tick(); arr_wr_start = 1'b0;
        check("R2 latch cleared by start", status_byte, 8'h01);
        measure(n);
        check("R9 array cycle length", n, WR_CYC);

        // R5 fill rejected with nonzero protect code
        set_prot(2'd1);
        do_wren();
        check("R5 fill blocked", fill_ok, 0);
        fill_start = 1'b1; tick(); fill_start = 1'b0;
        check("R5 fill rejected status", status_byte, 8'h06);
        do_wrdi();

        // R9 fill duration
        set_prot(2'd0);
        do_wren();
        fill_start = 1'b1; tick(); fill_start = 1'b0;
        measure(n);
        check("R9 fill cycle length", n, FILL_CYC);
        check("R9 idle after fill", status_byte, 8'h00);

        // R9 starts during busy ignored, latch kept
        do_wren();
        arr_wr_start = 1'b1; tick(); arr_wr_start = 1'b0;
        do_wren();
        check("R9 wren during busy", status_byte, 8'h03);
        fill_start = 1'b1; tick(); fill_start = 1'b0;
        measure(n);
        check("R9 busy not stretched", n, WR_CYC - 2);
        check("R9 latch survives", status_byte, 8'h02);

        // R4 new code visible during busy; rejected without latch
        new_prot = 2'd2; sr_wr_start = 1'b1; tick(); sr_wr_start = 1'b0;
        check("R4 new prot while busy", status_byte, 8'h09);
        wait_idle();
        new_prot = 2'd3; sr_wr_start = 1'b1; tick(); sr_wr_start = 1'b0;
        check("R4 rejected status write", status_byte, 8'h08);

        // R2 collision: wren with accepted start
        set_prot(2'd0);
        load_addr(11'h020);
        do_wren();
        wren_evt = 1'b1; arr_wr_start = 1'b1; tick();
        wren_evt = 1'b0; arr_wr_start = 1'b0;
        check("R2 collision latch clear", status_byte, 8'h01);
        wait_idle();

        // R6 address loads
        load_addr(11'h5A3);
        check("R6 addr load", cur_addr, 11'h5A3);
        // R7 read increment and wrap
        rd_ack = 1'b1; tick(); rd_ack = 1'b0;
        check("R7 read inc", cur_addr, 11'h5A4);
        load_addr(11'h7FF);
        rd_ack = 1'b1; tick(); rd_ack = 1'b0;
        check("R7 read wrap", cur_addr, 11'h000);
        // R8 page wrap
        load_addr(11'h12F);
        wr_ack = 1'b1; tick(); wr_ack = 1'b0;
        check("R8 page wrap", cur_addr, 11'h120);
        wr_ack = 1'b1; tick(); wr_ack = 1'b0;
        check("R8 page inc", cur_addr, 11'h121);
        // R11 load beats ack
        addr_byte = 8'h44; addr_lo_ld = 1'b1; rd_ack = 1'b1; tick();
        addr_lo_ld = 1'b0; rd_ack = 1'b0;
        check("R11 load wins", cur_addr, 11'h144);

        // R10 soft reset keeps protect code, power-on clears it
        set_prot(2'd2);
        do_wren();
        load_addr(11'h123);
        soft_rst = 1'b1; tick(); soft_rst = 1'b0;
        check("R10 soft status", status_byte, 8'h08);
        check("R10 soft addr", cur_addr, 0);
        por_n = 1'b0; tick(); por_n = 1'b1; tick();
        check("R10 por status", status_byte, 8'h00);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule